// File: doc/BRIEF.md
# MDIO Management Master with Command Register

This block drives Clause 22 management transactions toward external PHY devices over a two-wire serial management bus (MDC clock, bidirectional MDIO data). Software posts one 32-bit command word holding a valid flag, a PHY address, a register address, sixteen bits of write data and a one-hot operation selector. The block holds the command as pending until its frame engine is free. It then shifts a complete frame onto the wire and shows the transaction in a status word.

For a read, the block releases MDIO after the address fields and samples sixteen data bits from the PHY. It stores them, together with a pair of error bits, in a read-data word. The error bits are set when the PHY fails to pull the line low in the second turnaround slot. Software polls the pending flag before posting a new command, and polls the busy flag before collecting read results. The register side is a simple word-addressed 32-bit bus with one cycle of read latency. MDC is the system clock divided by an even parameter.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status word and the read-data word read as zero, MDC is low and MDIO is not driven (output enable low).
- R2: A write to byte offset 0x8 is accepted only when bit 31 (valid) is set and exactly one of bit 1 (write) and bit 2 (read) is set. The PHY address is in bits 29:25, the register address in bits 24:20 and the write data in bits 19:4. Any other command word sets no flag and starts no frame.
- R3: Status (offset 0x0) bit 2 is pending and bit 3 is busy. Pending reads as 1 on the first read after an accepted command, while busy is still 0. The frame then starts, pending clears and busy reads as 1 until the frame ends.
- R4: A command written while pending is already set is discarded. The held command is not changed.
- R5: MDC has a period of DIV system clocks and a 50% duty cycle, and stays low while no frame runs. MDIO changes only where MDC falls.
- R6: Every frame lasts 64 MDC periods and sends, MSB first, 32 ones, start 01, opcode 10 (read) or 01 (write), the PHY address and then the register address. A write frame continues with turnaround 10 and the 16 write data bits.
- R7: In a read frame, MDIO output enable drops for the last 18 bit slots (turnaround and data). Read-data bits 15:0 (offset 0xC) hold the 16 bits sampled on the MDC rising edges, MSB first.
- R8: Read-data bits 16 and 17 are both 1 when MDIO is high in the second turnaround slot of a read, and both 0 otherwise. A write frame leaves the read-data word unchanged.
- R9: Reads of offsets 0x4 and 0x8 return zero. Register read data appears one clock after the read strobe.
- R10: A command accepted while a frame is running shows pending and busy together, and its frame runs right after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid one cycle after bus_re |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A table of commands mixes reads and writes with all-zero, all-one and alternating address and data fields. Those field patterns show whether the PHY and register addresses sit in the correct bit positions and in MSB-first order on the wire. Read cases pair different PHY responses with a good or a missing turnaround zero, which separates correct data capture from error-flag handling. Directed sequences cover malformed command words, a command posted during a running frame and a third command posted while one is pending. These tell apart correct queueing and correct discarding from lost or duplicated frames.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PREAMBLE_LEN = 32;
  localparam int FRAME_LEN    = PREAMBLE_LEN + 32;

  // word indices of the register map (byte offset / 4)
  localparam int W_STATUS = 0;
  localparam int W_CMD    = 2;
  localparam int W_RDATA  = 3;

  // command word bit positions
  localparam int C_VALID = 31;
  localparam int C_PHY   = 25;
  localparam int C_REG   = 20;
  localparam int C_WD    = 4;
  localparam int C_RD    = 2;
  localparam int C_WR    = 1;

  // status word bit positions
  localparam int S_PEND = 2;
  localparam int S_BUSY = 3;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] wd;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign rise_o = en_i && wrap && !mdc_o;
  assign fall_o = en_i && wrap && mdc_o;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: clock parked low once the engine stops
  p_mdc_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  mdio_cmd_t  cmd_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       mdio_i,
  output logic       busy_o,
  output logic       mdio_o,
  output logic       mdio_oe_o,
  output logic       done_o,
  output logic       done_rd_o,
  output logic [15:0] rd_val_o,
  output logic       ta_err_o
);
  localparam int IW      = $clog2(FRAME_LEN);
  localparam int RELEASE = PREAMBLE_LEN + 14;
  localparam int TA2     = PREAMBLE_LEN + 15;
  localparam int DSTART  = PREAMBLE_LEN + 16;

  logic [FRAME_LEN-1:0] built;
  logic [FRAME_LEN-1:0] shift_q;
  logic [IW-1:0]        idx_q;
  logic [IW-1:0]        idx_n;
  logic                 rd_q;
  logic                 last_bit;

  assign built = {{PREAMBLE_LEN{1'b1}}, 2'b01,
                  cmd_i.rd ? 2'b10 : 2'b01,
                  cmd_i.phy, cmd_i.ra,
                  cmd_i.rd ? 2'b11 : 2'b10,
                  cmd_i.rd ? 16'hFFFF : cmd_i.wd};

  assign idx_n     = idx_q + 1'b1;
  assign last_bit  = (idx_q == IW'(FRAME_LEN - 1));
  assign done_o    = busy_o && fall_i && last_bit;
  assign done_rd_o = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
      shift_q   <= '0;
      idx_q     <= '0;
      rd_q      <= 1'b0;
      rd_val_o  <= '0;
      ta_err_o  <= 1'b0;
    end else if (start_i) begin
      busy_o    <= 1'b1;
      mdio_o    <= built[FRAME_LEN-1];
      mdio_oe_o <= 1'b1;
      shift_q   <= {built[FRAME_LEN-2:0], 1'b0};
      idx_q     <= '0;
      rd_q      <= cmd_i.rd;
      ta_err_o  <= 1'b0;
    end else if (busy_o) begin
      if (rise_i && rd_q) begin
        if (idx_q == IW'(TA2))
          ta_err_o <= mdio_i;
        if (int'(idx_q) >= DSTART)
          rd_val_o <= {rd_val_o[14:0], mdio_i};
      end
      if (fall_i) begin
        if (last_bit) begin
          busy_o    <= 1'b0;
          mdio_o    <= 1'b1;
          mdio_oe_o <= 1'b0;
        end else begin
          idx_q     <= idx_n;
          mdio_o    <= shift_q[FRAME_LEN-1];
          shift_q   <= {shift_q[FRAME_LEN-2:0], 1'b0};
          mdio_oe_o <= !(rd_q && (int'(idx_n) >= RELEASE));
        end
      end
    end
  end

  // R3: a started frame shows busy in the next cycle
  p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);

  // R5: MDIO only moves after an MDC fall or a frame start
  p_mdio_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(fall_i && busy_o) && !$past(start_i)) |-> $stable(mdio_o));

  // R7: the line is released through read turnaround and data
  p_read_release_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && rd_q && int'(idx_q) >= RELEASE) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic [15:0]       rd_val_i,
  input  logic              ta_err_i,
  output logic              pend_o,
  output mdio_cmd_t         cmd_o
);
  localparam int WW = ADDR_W - 2;

  logic [WW-1:0] word;
  logic          op_ok;
  logic          accept;
  logic [31:0]   rdata_q;

  assign word   = bus_addr[ADDR_W-1:2];
  assign op_ok  = bus_wdata[C_WR] ^ bus_wdata[C_RD];
  assign accept = bus_we && (word == WW'(W_CMD)) && bus_wdata[C_VALID]
                  && op_ok && !pend_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o  <= 1'b0;
      cmd_o   <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        pend_o     <= 1'b1;
        cmd_o.rd   <= bus_wdata[C_RD];
        cmd_o.phy  <= bus_wdata[C_PHY +: 5];
        cmd_o.ra   <= bus_wdata[C_REG +: 5];
        cmd_o.wd   <= bus_wdata[C_WD +: 16];
      end else if (start_i) begin
        pend_o <= 1'b0;
      end
      if (done_i && done_rd_i)
        rdata_q <= {14'd0, {2{ta_err_i}}, rd_val_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= '0;
      if (word == WW'(W_STATUS)) begin
        bus_rdata[S_PEND] <= pend_o;
        bus_rdata[S_BUSY] <= busy_i;
      end else if (word == WW'(W_RDATA)) begin
        bus_rdata <= rdata_q;
      end
    end
  end

  // R2: a word without the valid flag never raises pending
  p_ignore_invalid_r2: assert property (@(posedge clk) disable iff (rst)
    (!pend_o && bus_we && word == WW'(W_CMD) && !bus_wdata[C_VALID]) |=> !pend_o);

  // R3: the frame engine taking the command drops pending
  p_pend_drop_r3: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !pend_o);

  // R4: a held command is not overwritten while it waits
  p_hold_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !start_i) |=> (pend_o && $stable(cmd_o)));

  // R8: both error flags always agree
  p_err_pair_r8: assert property (@(posedge clk) disable iff (rst)
    rdata_q[16] == rdata_q[17]);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV    = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mdio_cmd_t   cmd;
  logic        pend;
  logic        busy;
  logic        start;
  logic        rise;
  logic        fall;
  logic        done;
  logic        done_rd;
  logic [15:0] rd_val;
  logic        ta_err;

  assign start = pend && !busy;

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_i(busy), .start_i(start), .done_i(done), .done_rd_i(done_rd),
    .rd_val_i(rd_val), .ta_err_i(ta_err),
    .pend_o(pend), .cmd_o(cmd)
  );

  mdio_clkgen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst(rst), .en_i(busy),
    .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start_i(start), .cmd_i(cmd),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .busy_o(busy), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .done_o(done), .done_rd_o(done_rd), .rd_val_o(rd_val), .ta_err_o(ta_err)
  );

  // R10: a waiting command enters the engine in the cycle after idle
  p_queue_start_r10: assert property (@(posedge clk) disable iff (rst)
    (pend && !busy) |=> busy);
endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.DIV(DIV), .ADDR_W(4)) i_mdio_mgmt_master (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model: records 64 slots per frame, answers reads
  int          nbit = 0;
  int          nframes = 0;
  logic [63:0] cap = '0, capoe = '0, last_frame = '0, last_oe = '0;
  logic [15:0] resp = '0;
  logic        ta_drive = 1'b0;
  time         t_rise = 0, t_prev_rise = 0, t_fall = 0;

  always @(posedge mdc) begin
    t_prev_rise = t_rise;
    t_rise = $time;
    cap[63-nbit]   = mdio_o;
    capoe[63-nbit] = mdio_oe;
    if (nbit == 63) begin
      last_frame = cap;
      last_oe    = capoe;
      nframes++;
      nbit = 0;
    end else begin
      nbit++;
    end
  end

  always @(negedge mdc) begin
    t_fall = $time;
    if (nbit < 47)       mdio_i = 1'b1;
    else if (nbit == 47) mdio_i = ta_drive;
    else                 mdio_i = resp[63-nbit];
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_read(4'h0, s);
      if (s[3:2] == 2'b00) break;
    end
  endtask

  function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] phy,
                                         input logic [4:0] ra, input logic [15:0] wd);
    return {1'b1, 1'b0, phy, ra, wd, 1'b0, rd, ~rd, 1'b0};
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b10, wd};
  endfunction

  typedef struct packed {
    bit          rd;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] wd;
    logic [15:0] resp;
    bit          tabad;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b0},
    '{1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 1'b0},
    '{1'b1, 5'h15, 5'h0A, 16'h0000, 16'hA55A, 1'b0},
    '{1'b0, 5'h0A, 5'h15, 16'h1234, 16'h0000, 1'b0},
    '{1'b1, 5'h01, 5'h10, 16'h0000, 16'h8001, 1'b1},
    '{1'b1, 5'h10, 5'h01, 16'h0000, 16'h7FFE, 1'b0}
  };

  localparam logic [63:0] RD_MASK = {{46{1'b1}}, 18'd0};

  initial begin
    logic [31:0] r;
    logic [31:0] exp_data;
    int          nf;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R9 unused offsets
    bus_read(4'h0, r); chk(r == 0, "R1 status after reset", r, 0);
    bus_read(4'hC, r); chk(r == 0, "R1 rdata after reset", r, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", {mdc, mdio_oe}, 0);
    bus_read(4'h8, r); chk(r == 0, "R9 cmd offset reads zero", r, 0);
    bus_read(4'h4, r); chk(r == 0, "R9 offset 4 reads zero", r, 0);
    exp_data = 0;

    // R2 malformed commands are ignored
    nf = nframes;
    bus_write(4'h8, mk_cmd(1'b0, 5'h3, 5'h4, 16'h55) & ~32'h8000_0000);
    bus_read(4'h0, r); chk(r == 0, "R2 valid clear ignored", r, 0);
    bus_write(4'h8, mk_cmd(1'b0, 5'h3, 5'h4, 16'h55) | 32'h6);
    bus_read(4'h0, r); chk(r == 0, "R2 both ops ignored", r, 0);
    bus_write(4'h8, mk_cmd(1'b0, 5'h3, 5'h4, 16'h55) & ~32'h6);
    bus_read(4'h0, r); chk(r == 0, "R2 no op ignored", r, 0);
    repeat (60) @(negedge clk);
    chk(nframes == nf && mdc == 1'b0, "R2 no frame from ignored words", nframes, nf);

    // R6 R7 R8 table of transactions
    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      resp = v.resp; ta_drive = v.tabad;
      nf = nframes;
      bus_write(4'h8, mk_cmd(v.rd, v.phy, v.ra, v.wd));
      wait_idle();
      repeat (2) @(negedge clk);
      chk(nframes == nf + 1, "R6 one frame per command", nframes, nf + 1);
      if (v.rd) begin
        chk((last_frame & RD_MASK) == (exp_frame(1'b1, v.phy, v.ra, 16'h0) & RD_MASK),
            "R6 read frame header", last_frame & RD_MASK,
            exp_frame(1'b1, v.phy, v.ra, 16'h0) & RD_MASK);
        chk(last_oe == RD_MASK, "R7 read release pattern", last_oe, RD_MASK);
        exp_data = {14'd0, {2{v.tabad}}, v.resp};
        bus_read(4'hC, r);
        chk(r == exp_data, v.tabad ? "R8 turnaround error flags" : "R7 read data", r, exp_data);
      end else begin
        chk(last_frame == exp_frame(1'b0, v.phy, v.ra, v.wd), "R6 write frame",
            last_frame, exp_frame(1'b0, v.phy, v.ra, v.wd));
        chk(last_oe == '1, "R6 write drives all slots", last_oe, '1);
        bus_read(4'hC, r);
        chk(r == exp_data, "R8 write leaves rdata", r, exp_data);
      end
    end

    // R5 MDC period and duty from the last frame
    chk((t_rise - t_prev_rise) == DIV * 4, "R5 MDC period", t_rise - t_prev_rise, DIV * 4);
    chk((t_fall - t_rise) == DIV * 2, "R5 MDC high time", t_fall - t_rise, DIV * 2);
    chk(mdc == 1'b0, "R5 MDC low when idle", mdc, 0);

    // R3 pending then busy, R10 queueing, R4 discard while pending
    nf = nframes;
    resp = 16'h0; ta_drive = 1'b0;
    bus_write(4'h8, mk_cmd(1'b0, 5'h02, 5'h03, 16'hBEEF));
    bus_read(4'h0, r); chk(r == 32'h4, "R3 pending before start", r, 32'h4);
    bus_read(4'h0, r); chk(r == 32'h8, "R3 busy after start", r, 32'h8);
    bus_write(4'h8, mk_cmd(1'b0, 5'h11, 5'h12, 16'hCAFE));
    bus_read(4'h0, r); chk(r == 32'hC, "R10 pending with busy", r, 32'hC);
    bus_write(4'h8, mk_cmd(1'b0, 5'h1E, 5'h1D, 16'h0F0F));
    wait_idle();
    repeat (2) @(negedge clk);
    chk(nframes == nf + 2, "R4 third command discarded", nframes, nf + 2);
    chk(last_frame == exp_frame(1'b0, 5'h11, 5'h12, 16'hCAFE), "R10 queued frame contents",
        last_frame, exp_frame(1'b0, 5'h11, 5'h12, 16'hCAFE));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule